// File: doc/BRIEF.md
# Static-Signal Auto-Mute Detector

This block watches one channel of signed audio samples, one sample per strobe. It classifies each accepted sample as silent or live. A sample is silent when all its bits are zero or all its bits are one. It counts how many identical silent samples arrive in a row. When the run reaches the threshold, the block raises a mute request. The first live sample drops the request again.

The request goes to a downstream level sequencer, which applies the mute with the same gradual, zero-crossing-aware stepping that it uses for volume changes. This block does no gain processing itself. A separate indicator output follows the mute state with a polarity chosen by a parameter, and is active low by default. A chip places one instance per channel, and the instances share nothing.

A single control input switches the feature off while it is high. Tying that input low leaves the detector enabled from reset onward.

Top module: `static_mute_detector`

## Requirements
- R1: After a run of RUN_LEN (default 8192) identical silent samples, `mute_req_o` is high starting from the clock edge that accepts the RUN_LEN-th sample of the run. It is never high earlier in that run.
- R2: A live sample releases the mute on the edge that accepts it. After a release, a complete new run of RUN_LEN silent samples is needed before the next mute.
- R3: Exactly two codes count as silent: all bits zero and all bits one (the value -1). Every other code is live, including 1, the most negative value and the most positive value.
- R4: A silent sample whose code differs from the current run (zero after all-ones, or all-ones after zero) starts a new run of length one. If the block was muted, that sample releases the mute.
- R5: A clock edge with `smp_valid_i` low changes neither the run nor `mute_req_o`.
- R6: The run length saturates at RUN_LEN. Once muted, a channel stays muted through silent runs of any length, including runs of more than twice RUN_LEN.
- R7: While `auto_off_i` is high, the next edge clears the run and `mute_req_o`, and samples are ignored. After `auto_off_i` returns low, counting starts from zero. Low means enabled.
- R8: With IND_ACTIVE_LOW = 1 (the default), `mute_ind_o` is the inverse of `mute_req_o` on every cycle. With IND_ACTIVE_LOW = 0, it equals `mute_req_o`.
- R9: Synchronous active-high `rst` leaves `mute_req_o` low, `mute_ind_o` inactive and the run empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| auto_off_i | input | 1 | High switches the detector off; low enables it |
| smp_valid_i | input | 1 | Sample strobe; the sample is accepted on an edge where this is high |
| smp_data_i | input | SAMPLE_W | Two's-complement sample |
| mute_req_o | output | 1 | Mute request to the level sequencer |
| mute_ind_o | output | 1 | Mute indicator, polarity set by IND_ACTIVE_LOW |

## Verification
A run counter that is off by one moves the mute edge by one sample. This shows up on the exact sample that should trip the mute, or on the one just before it. A counter that wraps instead of saturating releases a held mute partway through a long silent run. That happens at a known sample count near twice the threshold. A run-code register that fails to clear lets mixed zero and all-ones runs, or runs after the disable control, trip early. Every one of these faults appears as a wrong `mute_req_o` on the edge right after the offending sample.

// File: rtl/amute_pkg.sv
package amute_pkg;

    localparam int DEF_SAMPLE_W = 24;
    localparam int DEF_RUN_LEN  = 8192;

    // Silence class of one sample
    typedef enum logic [1:0] {
        CLS_LIVE = 2'd0,
        CLS_ZERO = 2'd1,
        CLS_ONES = 2'd2
    } lvl_cls_e;

    // Classified sample as it enters the run tracker
    typedef struct packed {
        logic     stb;
        lvl_cls_e cls;
    } smp_info_t;

    // A silent sample continues the current run only when it has the same code
    function automatic logic extends_run(input lvl_cls_e now_cls, input lvl_cls_e run_cls);
        return (now_cls != CLS_LIVE) && (now_cls == run_cls);
    endfunction

endpackage

// File: rtl/amute_classify.sv
module amute_classify
    import amute_pkg::*;
#(
    parameter int W = DEF_SAMPLE_W
) (
    input  logic         stb_i,
    input  logic [W-1:0] data_i,
    output smp_info_t    info_o
);

    logic all_zero;
    logic all_ones;

    assign all_zero = ~(|data_i);
    assign all_ones = &data_i;

    always_comb begin
        info_o.stb = stb_i;
        if (all_zero)      info_o.cls = CLS_ZERO;
        else if (all_ones) info_o.cls = CLS_ONES;
        else               info_o.cls = CLS_LIVE;
    end

endmodule

// File: rtl/amute_run_tracker.sv
module amute_run_tracker
    import amute_pkg::*;
#(
    parameter int RUN_LEN = DEF_RUN_LEN,
    parameter int CNT_W   = $clog2(RUN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             off_i,
    input  smp_info_t        info_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             reach_o
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LEN);

    lvl_cls_e         cls_q, cls_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cls_d = cls_q;
        cnt_d = cnt_q;
        if (off_i) begin
            cls_d = CLS_LIVE;
            cnt_d = '0;
        end else if (info_i.stb) begin
            if (info_i.cls == CLS_LIVE) begin
                cls_d = CLS_LIVE;
                cnt_d = '0;
            end else if (extends_run(info_i.cls, cls_q)) begin
                if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
            end else begin
                cls_d = info_i.cls;
                cnt_d = CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cls_q <= CLS_LIVE;
            cnt_q <= '0;
        end else begin
            cls_q <= cls_d;
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o   = cnt_q;
    assign reach_o = (cnt_d == LIMIT);

endmodule

// File: rtl/amute_flag_reg.sv
module amute_flag_reg #(
    parameter bit IND_ACTIVE_LOW = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    output logic mute_o,
    output logic ind_o
);

    logic mute_q;

    always_ff @(posedge clk) begin
        if (rst) mute_q <= 1'b0;
        else     mute_q <= set_i;
    end

    assign mute_o = mute_q;

    generate
        if (IND_ACTIVE_LOW) begin : g_ind_low
            assign ind_o = ~mute_q;
        end else begin : g_ind_high
            assign ind_o = mute_q;
        end
    endgenerate

endmodule

// File: rtl/static_mute_detector.sv
module static_mute_detector
    import amute_pkg::*;
#(
    parameter int SAMPLE_W       = DEF_SAMPLE_W,
    parameter int RUN_LEN        = DEF_RUN_LEN,
    parameter bit IND_ACTIVE_LOW = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                auto_off_i,
    input  logic                smp_valid_i,
    input  logic [SAMPLE_W-1:0] smp_data_i,
    output logic                mute_req_o,
    output logic                mute_ind_o
);

    localparam int CNT_W = $clog2(RUN_LEN + 1);

    smp_info_t        info;
    logic [CNT_W-1:0] run_cnt;
    logic             reach;

    amute_classify #(.W(SAMPLE_W)) cls_i (
        .stb_i  (smp_valid_i),
        .data_i (smp_data_i),
        .info_o (info)
    );

    amute_run_tracker #(.RUN_LEN(RUN_LEN), .CNT_W(CNT_W)) trk_i (
        .clk     (clk),
        .rst     (rst),
        .off_i   (auto_off_i),
        .info_i  (info),
        .cnt_o   (run_cnt),
        .reach_o (reach)
    );

    amute_flag_reg #(.IND_ACTIVE_LOW(IND_ACTIVE_LOW)) flg_i (
        .clk    (clk),
        .rst    (rst),
        .set_i  (reach),
        .mute_o (mute_req_o),
        .ind_o  (mute_ind_o)
    );

endmodule

// File: rtl/amute_checker.sv
module amute_checker #(
    parameter int W              = 24,
    parameter int RUN_LEN        = 8192,
    parameter int CNT_W          = 14,
    parameter bit IND_ACTIVE_LOW = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             auto_off_i,
    input logic             smp_valid_i,
    input logic [W-1:0]     smp_data_i,
    input logic             mute_req_o,
    input logic             mute_ind_o,
    input logic [CNT_W-1:0] run_cnt
);

    logic is_silent;
    assign is_silent = (&smp_data_i) || ~(|smp_data_i);

    AST_RISE_NEEDS_SILENT: assert property (@(posedge clk) disable iff (rst)
        $rose(mute_req_o) |-> $past(smp_valid_i && is_silent && !auto_off_i)); // R1

    AST_LIVE_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (smp_valid_i && !is_silent) |=> !mute_req_o); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!smp_valid_i && !auto_off_i) |=> $stable(mute_req_o)); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= CNT_W'(RUN_LEN)); // R6

    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        auto_off_i |=> (!mute_req_o && run_cnt == '0)); // R7

    AST_IND_POLARITY: assert property (@(posedge clk) disable iff (rst)
        mute_ind_o == (IND_ACTIVE_LOW ? !mute_req_o : mute_req_o)); // R8

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mute_req_o && run_cnt == '0)); // R9

endmodule

bind static_mute_detector amute_checker #(
    .W              (SAMPLE_W),
    .RUN_LEN        (RUN_LEN),
    .CNT_W          (CNT_W),
    .IND_ACTIVE_LOW (IND_ACTIVE_LOW)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .auto_off_i  (auto_off_i),
    .smp_valid_i (smp_valid_i),
    .smp_data_i  (smp_data_i),
    .mute_req_o  (mute_req_o),
    .mute_ind_o  (mute_ind_o),
    .run_cnt     (run_cnt)
);

// File: tb/static_mute_detector_tb_top.sv
`timescale 1ns/1ps
module static_mute_detector_tb_top;

    localparam int W   = 24;
    localparam int RUN = 8192;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         off = 1'b0;
    logic         vld = 1'b0;
    logic [W-1:0] dat = '0;
    logic         mreq;
    logic         mind;

    always #2.5 clk = ~clk;

    static_mute_detector #(.SAMPLE_W(W), .RUN_LEN(RUN), .IND_ACTIVE_LOW(1'b1)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .auto_off_i  (off),
        .smp_valid_i (vld),
        .smp_data_i  (dat),
        .mute_req_o  (mreq),
        .mute_ind_o  (mind)
    );

    typedef struct {
        logic  mute;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks   = 0;
    int   errors   = 0;
    int   mcnt     = 0;
    int   mcls     = 0;   // 0 live, 1 zero, 2 all-ones
    logic last_exp = 1'b0;
    bit   reported = 1'b0;

    function automatic void check(logic act, logic exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endfunction

    function automatic void report();
        if (!reported) begin
            reported = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
    endfunction

    // Driver: presents samples and pushes the mute state each one should produce
    task automatic send(logic [W-1:0] d, int n, int gap, string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            int   c;
            @(negedge clk);
            vld = 1'b1;
            dat = d;
            c = (d == '0) ? 1 : ((d == '1) ? 2 : 0);
            if (off) begin
                mcnt = 0; mcls = 0;
            end else if (c == 0) begin
                mcnt = 0; mcls = 0;
            end else if (c == mcls) begin
                if (mcnt < RUN) mcnt++;
            end else begin
                mcls = c; mcnt = 1;
            end
            e.mute = (mcnt == RUN);
            e.tag  = tag;
            q.push_back(e);
            if (gap > 0) begin
                @(negedge clk);
                vld = 1'b0;
                repeat (gap - 1) @(negedge clk);
            end
        end
        @(negedge clk);
        vld = 1'b0;
    endtask

    // Monitor: compares results after each edge; idle edges must hold the last state
    initial begin
        forever begin
            @(posedge clk);
            if (vld) begin
                #1;
                if (q.size() == 0) begin
                    check(1'b0, 1'b1, "scoreboard underflow");
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    last_exp = e.mute;
                    check(mreq, e.mute, e.tag);
                    check(mind, ~e.mute, "R8 indicator");
                end
            end else if (!rst && !off) begin
                #1;
                check(mreq, last_exp, "R5 idle hold");
            end
        end
    end

    initial begin
        #(195000 * 5);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        report();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        check(mreq, 1'b0, "R9 reset mute");
        check(mind, 1'b1, "R9 reset indicator");

        // R1: threshold on a zero run
        send('0, RUN - 1, 0, "R1 below threshold");
        send('0, 1, 0, "R1 threshold sample");
        // R6: saturation over a long run
        send('0, 2 * RUN + 10, 0, "R6 saturated run");
        // R2: single live sample releases; fresh run needed
        send(24'h000001, 1, 0, "R2 release");
        send('0, RUN - 1, 0, "R2 fresh run short");
        send('0, 1, 0, "R2 fresh run full");
        // R3: other codes are live, all-ones is silent
        send(24'h800000, 1, 0, "R3 most negative live");
        send('1, RUN, 0, "R3 all-ones run");
        send(24'h7FFFFF, 1, 0, "R3 most positive live");
        // R4: changing silent code restarts the run
        send('0, 5000, 0, "R4 zero part");
        send('1, 5000, 0, "R4 ones part");
        send('1, RUN - 5000, 0, "R4 ones complete");
        send('0, 1, 0, "R4 code change release");
        // R5: strobe gaps do not count or disturb
        send('0, RUN - 2, 3, "R5 gapped run");
        send('0, 1, 0, "R5 gapped threshold");
        repeat (20) @(negedge clk);
        // R7: disable clears and blocks
        @(negedge clk);
        off = 1'b1;
        mcnt = 0; mcls = 0;
        @(posedge clk); #1;
        check(mreq, 1'b0, "R7 disable releases");
        check(mind, 1'b1, "R7 disable indicator");
        send('0, 100, 0, "R7 ignored while off");
        @(negedge clk);
        last_exp = 1'b0;
        off = 1'b0;
        send('0, RUN - 1, 0, "R7 restart short");
        send('0, 1, 0, "R7 restart full");

        repeat (4) @(negedge clk);
        if (q.size() != 0) check(1'b0, 1'b1, "scoreboard leftover");
        report();
        $finish;
    end

endmodule